// File: doc/BRIEF.md
# Segment-Map Address Translation Unit

This unit turns a 32-bit virtual address into a physical address through two on-chip lookup memories. The first, the segment map, is indexed by the current context together with the virtual segment number and returns a page-group number. The second, the page-entry table, is indexed by that group number together with the virtual page number and returns a 32-bit page entry. The unit takes the frame number from that entry, appends the 12-bit page offset, and reports the cacheability and address-space type.

Before either memory is read, the unit checks whether the top three address bits fall in the unmapped hole. It then checks the entry for validity, write permission and supervisor-only access. When an access succeeds, the unit sets the used flag in the entry, and also the modified flag on a write, and writes the entry back into the table in the same cycle that it responds. Host ports load both tables and the context register. Every request takes a fixed three cycles, and the unit holds `busy` high while one is in flight.

The default sizes are scaled so that each memory stays small: a 2-bit context, a 9-bit segment field and 5-bit group numbers. Setting CTX_W=3, VSEG_W=12 and GRP_W=7 gives the full 15-bit segment index and 7-bit groups.

Top module: `smx_xlate`

## Requirements
- R1: If va[31:29] is neither 000 nor 111, the response carries fault code 1 (hole). Neither memory is read, nothing is written back, and resp_pte, resp_pa, resp_nc and resp_space are zero.
- R2: The segment map is read at index {context, va[18 +: VSEG_W]}, and the stored value is used as the page-group number.
- R3: The page-entry table is read at index {group, va[17:12]}. On success, resp_pa equals entry[18:0] shifted left by 12, ORed with va[11:0], with the upper bits zero.
- R4: A request seen with req_valid while busy is low is accepted at that clock edge (edge k). resp_valid is a one-cycle pulse that follows edge k+2. busy is high exactly in the two cycles after edges k and k+1. A request presented while busy is high is ignored and never produces a response.
- R5: An entry with bit 31 (valid) clear gives fault code 2 (invalid).
- R6: A write to an entry with bit 30 (writable) clear, or a user access to an entry with bit 29 (supervisor-only) set, gives fault code 3 (protection).
- R7: Fault priority is hole, then invalid, then protection. Fault code 0 means success.
- R8: On success, the entry is written back with bit 25 (used) set, and with bit 24 (modified) also set if the access is a write. resp_pte shows the written-back entry, and a later access to the same page sees it.
- R9: On a fault, nothing is written back, resp_pa, resp_nc and resp_space are zero, and resp_pte shows the entry exactly as read.
- R10: On success, resp_nc equals entry bit 28 and resp_space equals entry bits 27:26 (00 on-board memory, 01 on-board I/O, 10 16-bit bus, 11 32-bit bus).
- R11: The context register resets to 0. It is loaded by ctx_ld, and a new value applies to requests accepted after the loading edge.
- R12: During and after reset, resp_valid and busy are low, and resp_fault, resp_pa and resp_pte are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_ld | input | 1 | Load the context register |
| ctx_val | input | CTX_W | New context value |
| seg_ld | input | 1 | Write one segment-map entry |
| seg_ld_idx | input | CTX_W+VSEG_W | Segment-map index to write |
| seg_ld_grp | input | GRP_W | Page-group number to store |
| pte_ld | input | 1 | Write one page entry |
| pte_ld_idx | input | GRP_W+6 | Page-entry table index to write |
| pte_ld_val | input | 32 | Page entry to store |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address |
| req_wr | input | 1 | Request is a write |
| req_user | input | 1 | Request is from user mode |
| busy | output | 1 | A translation is in flight; requests are ignored |
| resp_valid | output | 1 | Response pulse |
| resp_pa | output | 32 | Physical address |
| resp_nc | output | 1 | Access must bypass caches |
| resp_space | output | 2 | Address-space type |
| resp_fault | output | 2 | 0 none, 1 hole, 2 invalid, 3 protection |
| resp_pte | output | 32 | Page entry after any update |

## Verification
The write-back is the hardest effect to see from the ports. It has no output of its own and shows only when a later request hits the same page. The stimulus therefore pairs accesses to one page: a write, then a read whose resp_pte must already carry the modified flag. It also makes a faulting write to a read-only page, followed by a read that must show the flag still clear. A second hard case is a request presented in the middle of a translation, which must disappear without a trace. The bench drives such a request in the cycle just after an acceptance and checks on every clock that no extra response pulse appears. The fault-priority case needs an entry that is invalid and would also fail the protection check, and the bench loads such an entry for it.

// File: rtl/smx_pkg.sv
package smx_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_HOLE    = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_PROT    = 2'd3
  } smx_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEG  = 2'd1,
    ST_PTE  = 2'd2
  } smx_state_e;

  // page-entry bit positions
  localparam int PB_VALID = 31;
  localparam int PB_WRITE = 30;
  localparam int PB_SUPER = 29;
  localparam int PB_NC    = 28;
  localparam int PB_SPACE = 26;
  localparam int PB_USED  = 25;
  localparam int PB_MOD   = 24;

  // top three address bits must be a sign extension
  function automatic logic va_in_hole(input logic [2:0] top);
    return !((top == 3'b000) || (top == 3'b111));
  endfunction

  function automatic smx_fault_e judge(input logic hole, input logic [31:0] ent,
                                       input logic wr, input logic usr);
    if (hole)                                   return FLT_HOLE;
    if (!ent[PB_VALID])                         return FLT_INVALID;
    if ((wr && !ent[PB_WRITE]) || (usr && ent[PB_SUPER])) return FLT_PROT;
    return FLT_NONE;
  endfunction

  function automatic logic [31:0] mark_entry(input logic [31:0] ent, input logic wr);
    logic [31:0] r;
    r = ent;
    r[PB_USED] = 1'b1;
    if (wr) r[PB_MOD] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/smx_lookup_ram.sv
module smx_lookup_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // synchronous read; host load overrides a write-back to the same index
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
    if (wb_en) mem[wb_idx] <= wb_data;
    if (ld_en) mem[ld_idx] <= ld_data;
  end
endmodule

// File: rtl/smx_access_chk.sv
module smx_access_chk
  import smx_pkg::*;
(
  input  logic        live,
  input  logic        hole,
  input  logic [31:0] entry,
  input  logic        wr,
  input  logic        usr,
  output smx_fault_e  fault,
  output logic        wb_en,
  output logic [31:0] wb_data
);
  always_comb begin
    fault   = judge(hole, entry, wr, usr);
    wb_en   = live && (fault == FLT_NONE);
    wb_data = mark_entry(entry, wr);
  end
endmodule

// File: rtl/smx_xlate.sv
module smx_xlate
  import smx_pkg::*;
#(
  parameter int CTX_W  = 2,
  parameter int VSEG_W = 9,
  parameter int GRP_W  = 5,
  parameter int PFN_W  = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctx_ld,
  input  logic [CTX_W-1:0]        ctx_val,
  input  logic                    seg_ld,
  input  logic [CTX_W+VSEG_W-1:0] seg_ld_idx,
  input  logic [GRP_W-1:0]        seg_ld_grp,
  input  logic                    pte_ld,
  input  logic [GRP_W+5:0]        pte_ld_idx,
  input  logic [31:0]             pte_ld_val,
  input  logic                    req_valid,
  input  logic [31:0]             req_va,
  input  logic                    req_wr,
  input  logic                    req_user,
  output logic                    busy,
  output logic                    resp_valid,
  output logic [31:0]             resp_pa,
  output logic                    resp_nc,
  output logic [1:0]              resp_space,
  output logic [1:0]              resp_fault,
  output logic [31:0]             resp_pte
);
  localparam int PG_W    = 6;
  localparam int OFF_W   = 12;
  localparam int PG_LSB  = OFF_W;
  localparam int SEG_LSB = PG_LSB + PG_W;
  localparam int SEG_AW  = CTX_W + VSEG_W;
  localparam int PTE_AW  = GRP_W + PG_W;
  localparam int LOW_W   = SEG_LSB;

  function automatic logic [31:0] phys_addr(input logic [31:0] ent,
                                            input logic [OFF_W-1:0] off);
    logic [31:0] p;
    p = '0;
    p[PG_LSB +: PFN_W] = ent[PFN_W-1:0];
    p[OFF_W-1:0]       = off;
    return p;
  endfunction

  smx_state_e          st;
  logic [CTX_W-1:0]    ctx_q;
  logic [LOW_W-1:0]    va_lo_q;
  logic                wr_q, usr_q, hole_q;
  logic [PTE_AW-1:0]   pte_idx_q;

  // named events for the checker
  logic                accept, hole_now;
  logic                seg_rd_en, pte_rd_en;
  logic [SEG_AW-1:0]   seg_rd_idx;
  logic [PTE_AW-1:0]   pte_rd_idx;
  logic [GRP_W-1:0]    seg_rd_data;
  logic [31:0]         pte_rd_data;
  logic [31:0]         chk_entry;
  smx_fault_e          chk_fault;
  logic                wb_en;
  logic [31:0]         wb_data;
  logic [31:0]         unused_va;

  assign unused_va  = req_va;
  assign busy       = (st != ST_IDLE);
  assign accept     = req_valid && (st == ST_IDLE);
  assign hole_now   = va_in_hole(req_va[31:29]);
  assign seg_rd_en  = accept && !hole_now;
  assign seg_rd_idx = {ctx_q, req_va[SEG_LSB +: VSEG_W]};
  assign pte_rd_en  = (st == ST_SEG) && !hole_q;
  assign pte_rd_idx = {seg_rd_data, va_lo_q[PG_LSB +: PG_W]};
  assign chk_entry  = hole_q ? '0 : pte_rd_data;

  smx_lookup_ram #(.AW(SEG_AW), .DW(GRP_W)) u_segmap (
    .clk     (clk),
    .rd_en   (seg_rd_en),
    .rd_idx  (seg_rd_idx),
    .rd_data (seg_rd_data),
    .ld_en   (seg_ld),
    .ld_idx  (seg_ld_idx),
    .ld_data (seg_ld_grp),
    .wb_en   (1'b0),
    .wb_idx  ('0),
    .wb_data ('0)
  );

  smx_lookup_ram #(.AW(PTE_AW), .DW(32)) u_ptetab (
    .clk     (clk),
    .rd_en   (pte_rd_en),
    .rd_idx  (pte_rd_idx),
    .rd_data (pte_rd_data),
    .ld_en   (pte_ld),
    .ld_idx  (pte_ld_idx),
    .ld_data (pte_ld_val),
    .wb_en   (wb_en),
    .wb_idx  (pte_idx_q),
    .wb_data (wb_data)
  );

  smx_access_chk u_access (
    .live    (st == ST_PTE),
    .hole    (hole_q),
    .entry   (chk_entry),
    .wr      (wr_q),
    .usr     (usr_q),
    .fault   (chk_fault),
    .wb_en   (wb_en),
    .wb_data (wb_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ctx_q <= '0;
    else if (ctx_ld) ctx_q <= ctx_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      va_lo_q   <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      hole_q    <= 1'b0;
      pte_idx_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st      <= ST_SEG;
          va_lo_q <= req_va[LOW_W-1:0];
          wr_q    <= req_wr;
          usr_q   <= req_user;
          hole_q  <= hole_now;
        end
        ST_SEG: begin
          st        <= ST_PTE;
          pte_idx_q <= pte_rd_idx;
        end
        ST_PTE:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_pa    <= '0;
      resp_nc    <= 1'b0;
      resp_space <= '0;
      resp_fault <= '0;
      resp_pte   <= '0;
    end else begin
      resp_valid <= (st == ST_PTE);
      if (st == ST_PTE) begin
        resp_fault <= chk_fault;
        if (chk_fault == FLT_NONE) begin
          resp_pa    <= phys_addr(chk_entry, va_lo_q[OFF_W-1:0]);
          resp_nc    <= chk_entry[PB_NC];
          resp_space <= chk_entry[PB_SPACE +: 2];
          resp_pte   <= wb_data;
        end else begin
          resp_pa    <= '0;
          resp_nc    <= 1'b0;
          resp_space <= '0;
          resp_pte   <= chk_entry;
        end
      end
    end
  end
endmodule

// File: rtl/smx_xlate_chk.sv
module smx_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        resp_valid,
  input logic [1:0]  resp_fault,
  input logic [31:0] resp_pa,
  input logic [31:0] resp_pte,
  input logic        resp_nc,
  input logic        wb_en,
  input logic        seg_rd_en,
  input logic        pte_rd_en
);
  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R4

  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R4

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy); // R4

  AST_HOLE_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == 2'd1) |-> (!$past(pte_rd_en, 2) && !$past(seg_rd_en, 3))); // R1

  AST_FAULT_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 2'd0) |-> !$past(wb_en)); // R9

  AST_FAULT_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 2'd0) |-> (resp_pa == 32'd0 && !resp_nc)); // R9

  AST_OK_MARKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == 2'd0) |-> (resp_pte[25] && resp_pte[31])); // R8

  AST_INVALID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == 2'd2) |-> !resp_pte[31]); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!resp_valid && !busy)); // R12
endmodule

bind smx_xlate smx_xlate_chk u_smx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .resp_valid (resp_valid),
  .resp_fault (resp_fault),
  .resp_pa    (resp_pa),
  .resp_pte   (resp_pte),
  .resp_nc    (resp_nc),
  .wb_en      (wb_en),
  .seg_rd_en  (seg_rd_en),
  .pte_rd_en  (pte_rd_en)
);

// File: tb/tb_smx_xlate.sv
`timescale 1ns/1ps
module tb_smx_xlate;
  localparam int CTX_W = 2, VSEG_W = 9, GRP_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctx_ld = 0; logic [CTX_W-1:0] ctx_val = '0;
  logic seg_ld = 0; logic [CTX_W+VSEG_W-1:0] seg_ld_idx = '0; logic [GRP_W-1:0] seg_ld_grp = '0;
  logic pte_ld = 0; logic [GRP_W+5:0] pte_ld_idx = '0; logic [31:0] pte_ld_val = '0;
  logic req_valid = 0; logic [31:0] req_va = '0; logic req_wr = 0, req_user = 0;
  logic busy, resp_valid, resp_nc;
  logic [31:0] resp_pa, resp_pte;
  logic [1:0] resp_space, resp_fault;

  always #4 clk = ~clk;

  smx_xlate dut (.*);

  typedef struct {
    int          due;
    logic [1:0]  flt;
    logic [31:0] pa;
    logic        nc;
    logic [1:0]  sp;
    logic [31:0] pte;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          seg_m[int];
  logic [31:0] pte_m[int];
  int          ctx_m = 0;
  int          cyc = 0, checks = 0, failures = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference queue
  always @(negedge clk) begin
    bit eb, ev;
    string t;
    eb = 0;
    foreach (exp_q[i]) if (cyc >= exp_q[i].due - 2 && cyc < exp_q[i].due) eb = 1;
    ev = (exp_q.size() > 0) && (exp_q[0].due == cyc);
    t = rst_n ? "R4" : "R12";
    chk(t, "busy", {31'd0, busy}, {31'd0, eb});
    chk(t, "resp_valid", {31'd0, resp_valid}, {31'd0, ev});
    if (ev) begin
      chk(exp_q[0].tag, "fault", {30'd0, resp_fault}, {30'd0, exp_q[0].flt});
      chk(exp_q[0].tag, "pa", resp_pa, exp_q[0].pa);
      chk(exp_q[0].tag, "nc", {31'd0, resp_nc}, {31'd0, exp_q[0].nc});
      chk(exp_q[0].tag, "space", {30'd0, resp_space}, {30'd0, exp_q[0].sp});
      chk(exp_q[0].tag, "pte", resp_pte, exp_q[0].pte);
      void'(exp_q.pop_front());
    end
  end

  task automatic set_ctx(int c);
    ctx_ld = 1; ctx_val = c[CTX_W-1:0];
    @(negedge clk); ctx_ld = 0; ctx_m = c;
  endtask

  task automatic load_seg(int c, int seg, int grp);
    seg_ld = 1; seg_ld_idx = (c * 512 + seg); seg_ld_grp = grp[GRP_W-1:0];
    seg_m[c * 512 + seg] = grp;
    @(negedge clk); seg_ld = 0;
  endtask

  task automatic load_pte(int grp, int pg, logic [31:0] v);
    pte_ld = 1; pte_ld_idx = (grp * 64 + pg); pte_ld_val = v;
    pte_m[grp * 64 + pg] = v;
    @(negedge clk); pte_ld = 0;
  endtask

  // behavioural reference: computes the response and applies write-back
  task automatic do_req(logic [31:0] va, bit wr, bit usr, string tag);
    exp_t e;
    int top, si, grp, pi;
    logic [31:0] ent;
    while (busy) @(negedge clk);
    req_valid = 1; req_va = va; req_wr = wr; req_user = usr;
    e.due = cyc + 3; e.tag = tag; e.pa = 0; e.nc = 0; e.sp = 0;
    top = int'(va >> 29);
    if (top != 0 && top != 7) begin
      e.flt = 2'd1; e.pte = 0;
    end else begin
      si  = ctx_m * 512 + int'((va >> 18) & 32'h1ff);
      grp = seg_m.exists(si) ? seg_m[si] : 0;
      pi  = grp * 64 + int'((va >> 12) & 32'h3f);
      ent = pte_m.exists(pi) ? pte_m[pi] : 32'h0;
      e.pte = ent;
      if (ent[31] == 1'b0) e.flt = 2'd2;
      else if ((wr && ent[30] == 1'b0) || (usr && ent[29] == 1'b1)) e.flt = 2'd3;
      else begin
        e.flt = 2'd0;
        ent = ent | 32'h0200_0000 | (wr ? 32'h0100_0000 : 32'h0);
        pte_m[pi] = ent;
        e.pte = ent;
        e.pa  = ((e.pte & 32'h7ffff) << 12) | (va & 32'hfff);
        e.nc  = e.pte[28];
        e.sp  = e.pte[27:26];
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "fault", {30'd0, resp_fault}, 32'd0);
    chk("R12", "pa", resp_pa, 32'd0);
    chk("R12", "pte", resp_pte, 32'd0);
    rst_n = 1;
    @(negedge clk);

    load_seg(0, 3, 5);
    load_seg(1, 3, 9);
    load_seg(0, 511, 2);
    load_pte(5, 1, 32'hC400_0000 | 32'h12345);  // valid, writable, user, I/O
    load_pte(9, 1, 32'hBC00_0000 | 32'h7ffff);  // valid, ro, super, nc, 32-bit bus
    load_pte(2, 63, 32'h2000_0000);             // invalid, ro, super
    load_pte(5, 2, 32'hE800_0000 | 32'h00abc);  // valid, writable, super, 16-bit bus

    do_req(32'h000C_1ABC, 0, 1, "R2 R3 R10 R11");   // context 0 from reset
    do_req(32'h000C_1ABC, 1, 1, "R8");
    do_req(32'h000C_1004, 0, 0, "R8");              // sees modified bit from write-back
    set_ctx(1);
    do_req(32'h000C_1FFF, 0, 0, "R10 R11");
    do_req(32'h000C_1000, 1, 0, "R6");              // write to read-only
    do_req(32'h000C_1000, 0, 0, "R9");              // modified still clear
    do_req(32'h000C_1000, 0, 1, "R6");              // user to supervisor
    set_ctx(0);
    do_req(32'h2000_0000, 0, 0, "R1");
    do_req(32'h4123_4567, 1, 1, "R1");
    do_req(32'hC000_0000, 0, 0, "R1");
    do_req(32'hFFFF_F000, 1, 1, "R5 R7");           // invalid wins over protection
    do_req(32'hFFFF_F123, 0, 0, "R5");
    do_req(32'h000C_2010, 0, 1, "R6");
    do_req(32'h000C_2010, 1, 0, "R3 R8 R10");
    // R4: a request while busy is dropped
    do_req(32'h000C_1000, 0, 0, "R4");
    req_valid = 1; req_va = 32'h000C_2000; req_wr = 1; req_user = 0;
    @(negedge clk); req_valid = 0;
    for (int i = 0; i < 8; i++) begin
      load_pte(5, 10 + i, 32'h8000_0000 | 32'h4000_0000 | (i << 26) | (i * 32'h1111));
      load_seg(0, 20 + i, 5);
    end
    for (int i = 0; i < 8; i++)
      do_req((20 + i) << 18 | (10 + i) << 12 | i * 37, i[0], 1, "R2 R3 R10");
    repeat (6) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule